// File: doc/BRIEF.md
# Crypto Stream Sideband Checker

This block watches a 512-bit AXI4-Stream input that feeds a symmetric cipher engine. On every beat that is accepted it decodes the 138-bit sideband word and the 32-bit transaction-ID word, then applies a fixed set of beat-level protocol rules. A report for each beat appears one cycle later: a status strobe, an error flag, a 5-bit error code, the normalised pattern, the packet-0 channel and a first-beat flag.

Each channel keeps its own sticky error bit. A rule violation sets that bit. While the bit is set, every later ordinary beat on the channel is refused with a dedicated code and leaves no other trace. Software returns a channel to service by sending one standalone clear beat on that channel. An internal-error pulse marks each cycle in which a new sticky error is recorded.

A two-state machine tracks packet framing:
- `S_GAP`: between packets.
- `S_BODY`: inside a packet.

The transitions are:
- `GAP_TO_BODY`: an accepted ordinary beat with last low.
- `BODY_TO_GAP`: an accepted ordinary beat with last high.
- Hold: every other case, including clear beats, which never move the state.

Framing follows the last bit even on beats that fail a rule.

Top module: `crypto_sideband_checker`

## Requirements
- R1: `s_ready` equals `m_ready` at all times. A beat is accepted when `s_valid` and `s_ready` are both high. `st_valid` is high in the cycle after an accepted beat and low in the cycle after any other cycle.
- R2: `st_pattern` reports sideband bits [5:3] when they hold 0 to 4, and reports 0 (idle) for the codes 5, 6 and 7.
- R3: `st_chan` reports transaction-ID bits [9:0]. The sticky table is indexed by the low log2(NUM_CH) bits of that field, so with 16 channels, channel 19 shares state with channel 3.
- R4: An ordinary beat with last low and any keep bit at zero reports error code 1.
- R5: An ordinary beat with last high whose keep mask is not a run of ones starting at byte 0 and followed only by zeros reports code 2. A fully zero mask counts as contiguous.
- R6: An ordinary beat on a channel whose sticky bit is set reports code 3. It sets no new error and produces no pulse.
- R7: A beat with sideband bit 137 set is a clear beat. It clears the sticky bit of its channel and reports no error, whatever the enable bits hold (bit 8 key, bit 6 IV/tweak, bit 7 data). It leaves the framing state unchanged.
- R8: An ordinary beat whose three enables (bits 8, 7, 6) are not exactly one-hot reports code 4.
- R9: Code priority is 3, then 4, then 1, then 2. Codes 1, 2 and 4 set the channel's sticky bit, and `int_err` pulses high together with that beat's status. `st_err` is high exactly when `st_code` is nonzero.
- R10: An active-low synchronous reset clears every sticky bit, clears `st_valid` and `int_err`, and returns framing to `S_GAP`.
- R11: `st_first` is high when the reported beat was accepted in `S_GAP`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input ready (equal to m_ready) |
| s_tid | input | 32 | Transaction ID word |
| s_keep | input | 64 | Byte keep mask |
| s_last | input | 1 | Last beat of a packet |
| s_user | input | 138 | Sideband word |
| m_ready | input | 1 | Downstream ready |
| st_valid | output | 1 | Status strobe |
| st_err | output | 1 | Beat error flag |
| st_code | output | 5 | Error code |
| st_pattern | output | 3 | Normalised pattern |
| st_chan | output | 10 | Packet-0 channel field |
| st_first | output | 1 | Beat was first of a packet |
| int_err | output | 1 | New sticky error pulse |

## Verification
A wrong sticky bit shows at the ports only when the next ordinary beat on the same channel, or on an aliasing channel, is reported. It then appears as a missing or spurious code 3 one cycle after that beat. A framing state that is off shows up as a wrong `st_first` on the very next reported beat. Code priority and the keep rules are visible on the same report cycle as the offending beat, so the stimulus pairs every sticky event with a later probe beat.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int USER_W = 138;
    localparam int TID_W  = 32;
    localparam int KEEP_W = 64;
    localparam int CODE_W = 5;

    localparam int B_PAT_LO = 3;
    localparam int B_IV     = 6;
    localparam int B_DATA   = 7;
    localparam int B_KEY    = 8;
    localparam int B_CLR    = 137;

    typedef enum logic [2:0] {
        PAT_IDLE = 3'd0,
        PAT_GCM  = 3'd1,
        PAT_MACS = 3'd2,
        PAT_IPS  = 3'd3,
        PAT_XTS  = 3'd4
    } pat_e;

    localparam logic [CODE_W-1:0] EC_NONE   = 5'd0;
    localparam logic [CODE_W-1:0] EC_NULL   = 5'd1;
    localparam logic [CODE_W-1:0] EC_HOLE   = 5'd2;
    localparam logic [CODE_W-1:0] EC_LOCKED = 5'd3;
    localparam logic [CODE_W-1:0] EC_ENABLE = 5'd4;

    typedef struct packed {
        logic [9:0] chan;
        pat_e       pat;
        logic       clr;
        logic [2:0] en;
    } beat_t;
endpackage

// File: rtl/sb_decode.sv
module sb_decode
    import sb_pkg::*;
(
    input  logic [USER_W-1:0] user,
    input  logic [TID_W-1:0]  tid,
    output beat_t             beat
);
    logic [2:0] raw_pat;
    assign raw_pat = user[B_PAT_LO +: 3];

    always_comb begin
        beat.chan = tid[9:0];
        beat.clr  = user[B_CLR];
        beat.en   = {user[B_KEY], user[B_DATA], user[B_IV]};
        if (raw_pat <= 3'd4) beat.pat = pat_e'(raw_pat);
        else                 beat.pat = PAT_IDLE;
    end
endmodule

// File: rtl/sb_rules.sv
module sb_rules
    import sb_pkg::*;
(
    input  beat_t              beat,
    input  logic [KEEP_W-1:0]  keep,
    input  logic               last,
    input  logic               locked,
    output logic [CODE_W-1:0]  code,
    output logic               new_err
);
    logic onehot_en, full_keep, contig_keep;

    assign onehot_en   = $onehot(beat.en);
    assign full_keep   = &keep;
    assign contig_keep = ((keep & (keep + 1'b1)) == '0);

    always_comb begin
        code = EC_NONE;
        if (!beat.clr) begin
            if (locked)                   code = EC_LOCKED;
            else if (!onehot_en)          code = EC_ENABLE;
            else if (!last && !full_keep) code = EC_NULL;
            else if (last && !contig_keep) code = EC_HOLE;
        end
        new_err = (code != EC_NONE) && (code != EC_LOCKED);
    end
endmodule

// File: rtl/sb_sticky.sv
module sb_sticky #(
    parameter int NUM_CH = 16,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             set_en,
    input  logic             clr_en,
    output logic             locked
);
    logic [NUM_CH-1:0] flag;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)                                 flag[g] <= 1'b0;
            else if (clr_en && (idx == IDX_W'(g)))      flag[g] <= 1'b0;
            else if (set_en && (idx == IDX_W'(g)))      flag[g] <= 1'b1;
        end
    end

    assign locked = flag[idx];
endmodule

// File: rtl/crypto_sideband_checker.sv
module crypto_sideband_checker
    import sb_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         s_valid,
    output logic         s_ready,
    input  logic [31:0]  s_tid,
    input  logic [63:0]  s_keep,
    input  logic         s_last,
    input  logic [137:0] s_user,
    input  logic         m_ready,
    output logic         st_valid,
    output logic         st_err,
    output logic [4:0]   st_code,
    output logic [2:0]   st_pattern,
    output logic [9:0]   st_chan,
    output logic         st_first
    ,output logic        int_err
);
    typedef enum logic {S_GAP = 1'b0, S_BODY = 1'b1} frame_e;

    frame_e              state, state_nx;
    beat_t               beat;
    logic [CODE_W-1:0]   code;
    logic                new_err, locked, accept;

    assign s_ready = m_ready;
    assign accept  = s_valid && m_ready;

    sb_decode u_dec (.user(s_user), .tid(s_tid), .beat(beat));

    sb_rules u_rules (
        .beat(beat), .keep(s_keep), .last(s_last), .locked(locked),
        .code(code), .new_err(new_err)
    );

    sb_sticky #(.NUM_CH(NUM_CH)) u_sticky (
        .clk(clk), .rst_n(rst_n),
        .idx(beat.chan[IDX_W-1:0]),
        .set_en(accept && new_err),
        .clr_en(accept && beat.clr),
        .locked(locked)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            S_GAP:  if (accept && !beat.clr && !s_last) state_nx = S_BODY;
            S_BODY: if (accept && !beat.clr && s_last)  state_nx = S_GAP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_GAP;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_valid   <= 1'b0;
            st_err     <= 1'b0;
            st_code    <= EC_NONE;
            st_pattern <= 3'd0;
            st_chan    <= '0;
            st_first   <= 1'b0;
            int_err    <= 1'b0;
        end else begin
            st_valid <= accept;
            int_err  <= accept && new_err;
            if (accept) begin
                st_err     <= (code != EC_NONE);
                st_code    <= code;
                st_pattern <= beat.pat;
                st_chan    <= beat.chan;
                st_first   <= (state == S_GAP);
            end
        end
    end
endmodule

// File: rtl/sb_check_props.sv
module sb_check_props (
    input logic         clk,
    input logic         rst_n,
    input logic         s_valid,
    input logic         s_ready,
    input logic [137:0] s_user,
    input logic         m_ready,
    input logic         st_valid,
    input logic         st_err,
    input logic [4:0]   st_code,
    input logic [2:0]   st_pattern,
    input logic         int_err
);
    p_status_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> st_valid);
    p_quiet_without_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_valid && m_ready) |=> !st_valid);
    p_pattern_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (st_pattern <= 3'd4));
    p_clear_reports_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && s_user[137]) |=> (!st_err && !int_err));
    p_flag_matches_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (st_err == (st_code != 5'd0)));
    p_pulse_only_new_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int_err |-> (st_valid && st_err && st_code != 5'd3));
endmodule

bind crypto_sideband_checker sb_check_props u_props (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_user(s_user), .m_ready(m_ready), .st_valid(st_valid),
    .st_err(st_err), .st_code(st_code), .st_pattern(st_pattern),
    .int_err(int_err)
);

// File: tb/sim_crypto_sideband_checker.sv
`timescale 1ns/1ps
module sim_crypto_sideband_checker;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         s_valid = 1'b0, s_ready, s_last = 1'b0, m_ready = 1'b1;
    logic [31:0]  s_tid = '0;
    logic [63:0]  s_keep = '0;
    logic [137:0] s_user = '0;
    logic         st_valid, st_err, st_first, int_err;
    logic [4:0]   st_code;
    logic [2:0]   st_pattern;
    logic [9:0]   st_chan;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    crypto_sideband_checker u0 (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .s_tid(s_tid), .s_keep(s_keep), .s_last(s_last), .s_user(s_user),
        .m_ready(m_ready), .st_valid(st_valid), .st_err(st_err),
        .st_code(st_code), .st_pattern(st_pattern), .st_chan(st_chan),
        .st_first(st_first), .int_err(int_err)
    );

    typedef struct packed {
        logic [9:0]  ch;
        logic [63:0] keep;
        logic        last;
        logic [2:0]  en;     // {key, data, iv}
        logic        clr;
        logic [2:0]  pat;
        logic [4:0]  xcode;
        logic        xpulse;
        logic [2:0]  xpat;
        logic        xfirst;
    } vec_t;

    localparam logic [63:0] ALL = {64{1'b1}};
    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{10'd1,  ALL,          1'b0, 3'b010, 1'b0, 3'd1, 5'd0, 1'b0, 3'd1, 1'b1}, // R1 R11 start
        '{10'd1,  ALL,          1'b1, 3'b010, 1'b0, 3'd1, 5'd0, 1'b0, 3'd1, 1'b0}, // R11 body
        '{10'd2,  ALL,          1'b1, 3'b010, 1'b0, 3'd5, 5'd0, 1'b0, 3'd0, 1'b1}, // R2 reserved
        '{10'd3,  64'hFFF,      1'b0, 3'b010, 1'b0, 3'd2, 5'd1, 1'b1, 3'd2, 1'b1}, // R4
        '{10'd3,  ALL,          1'b1, 3'b010, 1'b0, 3'd2, 5'd3, 1'b0, 3'd2, 1'b0}, // R6
        '{10'd4,  64'hF0,       1'b1, 3'b010, 1'b0, 3'd3, 5'd2, 1'b1, 3'd3, 1'b1}, // R5
        '{10'd5,  ALL,          1'b1, 3'b011, 1'b0, 3'd1, 5'd4, 1'b1, 3'd1, 1'b1}, // R8
        '{10'd6,  ALL,          1'b1, 3'b000, 1'b0, 3'd1, 5'd4, 1'b1, 3'd1, 1'b1}, // R8 none
        '{10'd19, ALL,          1'b1, 3'b010, 1'b0, 3'd1, 5'd3, 1'b0, 3'd1, 1'b1}, // R3 alias
        '{10'd3,  ALL,          1'b1, 3'b111, 1'b1, 3'd1, 5'd0, 1'b0, 3'd1, 1'b1}, // R7 clear
        '{10'd3,  ALL,          1'b1, 3'b010, 1'b0, 3'd1, 5'd0, 1'b0, 3'd1, 1'b1}, // R7 reuse
        '{10'd4,  64'h0F,       1'b0, 3'b100, 1'b0, 3'd1, 5'd3, 1'b0, 3'd1, 1'b1}, // R9 3 over 1
        '{10'd7,  64'hFF,       1'b1, 3'b001, 1'b0, 3'd4, 5'd0, 1'b0, 3'd4, 1'b0}, // R5 ok tail
        '{10'd7,  64'h0,        1'b1, 3'b100, 1'b0, 3'd7, 5'd0, 1'b0, 3'd0, 1'b1}  // R2 R5 empty
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [9:0] ch, input logic [63:0] keep, input logic last,
                         input logic [2:0] en, input logic clr, input logic [2:0] pat);
        s_valid = 1'b1;
        s_tid   = {22'd0, ch};
        s_keep  = keep;
        s_last  = last;
        s_user  = '0;
        s_user[137]  = clr;
        s_user[8:6]  = en;
        s_user[5:3]  = pat;
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 st_valid in reset", {15'd0, st_valid}, 16'd0);
        check("R10 int_err in reset", {15'd0, int_err}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].ch, VEC[i].keep, VEC[i].last, VEC[i].en, VEC[i].clr, VEC[i].pat);
            @(negedge clk);
            check("R1 st_valid", {15'd0, st_valid}, 16'd1);
            check("R9 st_code", {11'd0, st_code}, {11'd0, VEC[i].xcode});
            check("R9 st_err", {15'd0, st_err}, {15'd0, VEC[i].xcode != 5'd0});
            check("R9 int_err", {15'd0, int_err}, {15'd0, VEC[i].xpulse});
            check("R2 st_pattern", {13'd0, st_pattern}, {13'd0, VEC[i].xpat});
            check("R3 st_chan", {6'd0, st_chan}, {6'd0, VEC[i].ch});
            check("R11 st_first", {15'd0, st_first}, {15'd0, VEC[i].xfirst});
        end

        // R1: stall, ready follows downstream, no status
        drive(10'd8, ALL, 1'b1, 3'b010, 1'b0, 3'd1);
        m_ready = 1'b0;
        #1;
        check("R1 s_ready low", {15'd0, s_ready}, 16'd0);
        @(negedge clk);
        check("R1 no status when stalled", {15'd0, st_valid}, 16'd0);
        m_ready = 1'b1;
        s_valid = 1'b0;
        @(negedge clk);
        check("R1 idle cycle quiet", {15'd0, st_valid}, 16'd0);

        // R10: reset clears sticky of channel 4 and framing
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(10'd4, ALL, 1'b1, 3'b010, 1'b0, 3'd1);
        @(negedge clk);
        check("R10 sticky cleared", {11'd0, st_code}, 16'd0);
        check("R10 framing gap", {15'd0, st_first}, 16'd1);

        // R7: clear beat does not move framing (inside packet)
        drive(10'd9, ALL, 1'b0, 3'b010, 1'b0, 3'd1);
        @(negedge clk);
        drive(10'd9, ALL, 1'b1, 3'b000, 1'b1, 3'd1);
        @(negedge clk);
        check("R7 clear no error", {15'd0, st_err}, 16'd0);
        drive(10'd9, ALL, 1'b1, 3'b010, 1'b0, 3'd1);
        @(negedge clk);
        check("R7 clear keeps framing", {15'd0, st_first}, 16'd0);
        s_valid = 1'b0;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule